// File: doc/BRIEF.md
# Periodic Tick Down-Counter

A 24-bit down-counter that fires at a fixed rate. Software sets a reload value and turns the counter on. From then on the counter steps from the reload value down to zero. It then reloads and starts over. Each step is taken either on every core clock or only on cycles where a synchronous reference strobe is high. Every wrap through zero sets a sticky wrapped flag. When enabled, a wrap also raises a single-cycle exception request.

Software reaches the block through a simple single-cycle register port. Reads are combinational and are valid during the access cycle. Writes take effect at the end of that cycle. Some accesses have side effects:
- Reading the control word clears the wrapped flag.
- Writing any value to the current-count word restarts the period.
- A reload value of zero makes the counter switch itself off after its next wrap.

Top module: `sys_tick_timer`

## Requirements
- R1: Byte offsets are 0x10 control, 0x14 reload, 0x18 current count and 0x1C calibration. The calibration word reads decimal 10000 and ignores writes. Any other offset reads zero.
- R2: The control word holds run at bit 0, wrap-interrupt enable at bit 1, core-clock source at bit 2 and the wrapped flag at bit 16. Only bits 2:0 are writable, and all other bits read zero.
- R3: A control-word read returns the flag as it stood and clears it at the end of the access. If a wrap falls in that same cycle, the flag ends up set.
- R4: When run goes from 0 to 1, the count loads the reload value. No load happens while run is 0, and the current count reads zero while run is 0.
- R5: With run set, the count steps down by one on each counting tick, and a period is reload+1 ticks. With source bit 2 = 1 every clock is a tick. With bit 2 = 0 only cycles with the reference strobe high are ticks.
- R6: A tick at count zero is a wrap. A wrap sets the flag and reloads the count. If bit 1 is set, the interrupt output is high for exactly the one cycle after the wrap edge, and it stays low otherwise.
- R7: A wrap with reload value zero clears run. A control write in the same cycle takes precedence over this self-clear.
- R8: A write of any data to the current-count word reloads the count (only while run is set) and clears the flag. In the same cycle as a wrap, that write suppresses the wrap: no flag, no interrupt.
- R9: Reload and current count are 24 bits wide. Bits 31:24 read zero and are ignored on write.
- R10: After reset every register and the interrupt output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Synchronous reference tick strobe |
| bus_sel_i | input | 1 | Register access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid during the access cycle |
| wrap_irq_o | output | 1 | One-cycle exception request on wrap |

## Verification
Two functions can land in one cycle: a software side effect on the flag or count, and a hardware wrap. The bench counts clock edges from the enabling write, so it can place a control-word read exactly on the wrap edge. It expects that read to return the flag clear, and the next read to return it set. In the same way, it places a current-count write on the wrap edge and expects no flag, no interrupt and a fresh count. It also places a control write on the wrap edge of a zero reload and expects run to survive for exactly one more wrap.

// File: rtl/sys_tick_pkg.sv
package sys_tick_pkg;
  // register byte offsets
  localparam int unsigned OFS_CTRL    = 32'h10;
  localparam int unsigned OFS_RELOAD  = 32'h14;
  localparam int unsigned OFS_CURRENT = 32'h18;
  localparam int unsigned OFS_CALIB   = 32'h1C;

  // control word bit positions
  localparam int unsigned BIT_RUN      = 0;
  localparam int unsigned BIT_WRAP_IRQ = 1;
  localparam int unsigned BIT_CORE_CLK = 2;
  localparam int unsigned BIT_WRAPPED  = 16;
  localparam int unsigned CTRL_WR_BITS = 3;

  // writable control bits, packed to match bits 2:0
  typedef struct packed {
    logic core_clk;
    logic wrap_irq;
    logic run;
  } tick_ctrl_t;
endpackage

// File: rtl/stt_bus_decode.sv
module stt_bus_decode
  import sys_tick_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned CAL_VALUE = 10000
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  tick_ctrl_t        ctrl_i,
  input  logic              wrapped_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              ctrl_wr_o,
  output logic              ctrl_rd_o,
  output logic              reload_wr_o,
  output logic              count_wr_o,
  output tick_ctrl_t        ctrl_wdata_o,
  output logic [CNT_W-1:0]  reload_wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic hit_ctrl, hit_reload, hit_count, hit_calib;
  logic rd_acc, wr_acc;

  always_comb begin
    hit_ctrl   = (addr_i == ADDR_W'(OFS_CTRL));
    hit_reload = (addr_i == ADDR_W'(OFS_RELOAD));
    hit_count  = (addr_i == ADDR_W'(OFS_CURRENT));
    hit_calib  = (addr_i == ADDR_W'(OFS_CALIB));
    rd_acc     = sel_i & ~we_i;
    wr_acc     = sel_i & we_i;
  end

  // write strobes; a calibration write has no target
  assign ctrl_wr_o      = wr_acc & hit_ctrl;
  assign ctrl_rd_o      = rd_acc & hit_ctrl;
  assign reload_wr_o    = wr_acc & hit_reload;
  assign count_wr_o     = wr_acc & hit_count;
  assign ctrl_wdata_o   = tick_ctrl_t'(wdata_i[CTRL_WR_BITS-1:0]);
  assign reload_wdata_o = wdata_i[CNT_W-1:0];

  // combinational read mux
  always_comb begin
    rdata_o = '0;
    if (rd_acc) begin
      if (hit_ctrl) begin
        rdata_o[BIT_RUN]      = ctrl_i.run;
        rdata_o[BIT_WRAP_IRQ] = ctrl_i.wrap_irq;
        rdata_o[BIT_CORE_CLK] = ctrl_i.core_clk;
        rdata_o[BIT_WRAPPED]  = wrapped_i;
      end else if (hit_reload) begin
        rdata_o = DATA_W'(reload_i);
      end else if (hit_count) begin
        rdata_o = ctrl_i.run ? DATA_W'(count_i) : '0;
      end else if (hit_calib) begin
        rdata_o = DATA_W'(CAL_VALUE);
      end
    end
  end
endmodule

// File: rtl/stt_ctrl_regs.sv
module stt_ctrl_regs
  import sys_tick_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             ctrl_rd_i,
  input  logic             reload_wr_i,
  input  logic             count_wr_i,
  input  tick_ctrl_t       ctrl_wdata_i,
  input  logic [CNT_W-1:0] reload_wdata_i,
  input  logic             wrap_i,
  output tick_ctrl_t       ctrl_o,
  output logic             wrapped_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             start_o
);
  tick_ctrl_t       ctrl_q, ctrl_d;
  logic             wrapped_q, wrapped_d;
  logic [CNT_W-1:0] reload_q, reload_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr_i) begin
      ctrl_d = ctrl_wdata_i;
    end else if (wrap_i && (reload_q == '0)) begin
      ctrl_d.run = 1'b0;
    end

    wrapped_d = wrapped_q;
    if (wrap_i) begin
      wrapped_d = 1'b1;
    end else if (ctrl_rd_i || count_wr_i) begin
      wrapped_d = 1'b0;
    end

    reload_d = reload_wr_i ? reload_wdata_i : reload_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      wrapped_q <= 1'b0;
      reload_q  <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      wrapped_q <= wrapped_d;
      if (reload_wr_i) begin
        reload_q <= reload_d;
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign wrapped_o = wrapped_q;
  assign reload_o  = reload_q;
  assign start_o   = ctrl_wr_i & ctrl_wdata_i.run & ~ctrl_q.run;

  p_self_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && (reload_q == '0) && !ctrl_wr_i) |=> !ctrl_q.run);

  p_wrap_sets_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> wrapped_q);

  p_flag_cleared_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctrl_rd_i || count_wr_i) && !wrap_i) |=> !wrapped_q);
endmodule

// File: rtl/stt_down_counter.sv
module stt_down_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             core_clk_i,
  input  logic             wrap_irq_en_i,
  input  logic             ref_tick_i,
  input  logic             start_i,
  input  logic             count_wr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             irq_q, irq_d;
  logic             tick, at_zero, load;

  always_comb begin
    tick    = run_i & (core_clk_i | ref_tick_i);
    at_zero = (count_q == '0);
    wrap_o  = tick & at_zero & ~count_wr_i;
    load    = start_i | (count_wr_i & run_i) | wrap_o;
    count_d = count_q;
    if (load) begin
      count_d = reload_i;
    end else if (tick && !at_zero) begin
      count_d = count_q - 1'b1;
    end
    irq_d = wrap_o & wrap_irq_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (load || tick) begin
        count_q <= count_d;
      end
      irq_q <= irq_d;
    end
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;

  p_step_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !at_zero && !count_wr_i) |=> (count_q == $past(count_q) - 1'b1));

  p_restart_on_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_wr_i && run_i) |=> (count_q == $past(reload_i)));

  p_hold_when_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i) |=> $stable(count_q));
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import sys_tick_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CAL_VALUE = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              wrap_irq_o
);
  localparam int unsigned SYNC_STAGES = 2;

  // asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[SYNC_STAGES-1];

  tick_ctrl_t       ctrl, ctrl_wdata;
  logic             wrapped, wrap, start;
  logic             ctrl_wr, ctrl_rd, reload_wr, count_wr;
  logic [CNT_W-1:0] reload, reload_wdata, count;

  stt_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CAL_VALUE(CAL_VALUE)
  ) i_decode (
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .ctrl_i(ctrl), .wrapped_i(wrapped), .reload_i(reload), .count_i(count),
    .ctrl_wr_o(ctrl_wr), .ctrl_rd_o(ctrl_rd), .reload_wr_o(reload_wr),
    .count_wr_o(count_wr), .ctrl_wdata_o(ctrl_wdata), .reload_wdata_o(reload_wdata),
    .rdata_o(bus_rdata_o)
  );

  stt_ctrl_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_n),
    .ctrl_wr_i(ctrl_wr), .ctrl_rd_i(ctrl_rd), .reload_wr_i(reload_wr),
    .count_wr_i(count_wr), .ctrl_wdata_i(ctrl_wdata), .reload_wdata_i(reload_wdata),
    .wrap_i(wrap), .ctrl_o(ctrl), .wrapped_o(wrapped), .reload_o(reload),
    .start_o(start)
  );

  stt_down_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i(clk_i), .rst_ni(rst_n),
    .run_i(ctrl.run), .core_clk_i(ctrl.core_clk), .wrap_irq_en_i(ctrl.wrap_irq),
    .ref_tick_i(ref_tick_i), .start_i(start), .count_wr_i(count_wr),
    .reload_i(reload), .count_o(count), .wrap_o(wrap), .irq_o(wrap_irq_o)
  );

  p_start_loads_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(ctrl.run) |-> (count == $past(reload)));

  p_irq_has_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    wrap_irq_o |-> wrapped);

  p_irq_needs_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    wrap_irq_o |-> $past(ctrl.wrap_irq));
endmodule

// File: tb/test_sys_tick_timer.sv
module test_sys_tick_timer;
  localparam int unsigned A_CTRL = 8'h10;
  localparam int unsigned A_RLD  = 8'h14;
  localparam int unsigned A_CUR  = 8'h18;
  localparam int unsigned A_CAL  = 8'h1C;
  localparam int unsigned FLAG   = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_tick;
  logic        sel, we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  always #4 clk = ~clk;

  sys_tick_timer i_sys_tick_timer (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .wrap_irq_o(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic quiesce();
    logic [31:0] v;
    bus_wr(A_CTRL, 32'h0);
    bus_rd(A_CTRL, v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R10", "irq after reset", {31'b0, irq}, 32'h0);
    bus_rd(A_CTRL, v); check("R10", "ctrl after reset", v, 32'h0);
    bus_rd(A_RLD, v);  check("R10", "reload after reset", v, 32'h0);
    bus_rd(A_CUR, v);  check("R10", "current after reset", v, 32'h0);
    bus_rd(A_CAL, v);  check("R1", "calibration", v, 32'd10000);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    bus_wr(A_CTRL, 32'hFFFF_FFF8);
    bus_rd(A_CTRL, v); check("R2", "read-only ctrl bits", v, 32'h0);
    bus_wr(A_RLD, 32'hFFFF_FFFF);
    bus_rd(A_RLD, v);  check("R9", "reload width", v, 32'h00FF_FFFF);
    bus_wr(A_CAL, 32'h5);
    bus_rd(A_CAL, v);  check("R1", "calibration write ignored", v, 32'd10000);
    bus_rd(8'h00, v);  check("R1", "unmapped offset", v, 32'h0);
    bus_wr(A_CUR, 32'h1234);
    bus_rd(A_CUR, v);  check("R4", "current while off", v, 32'h0);
  endtask

  task automatic t_period();
    logic [31:0] v;
    int first_k, second_k, hits;
    quiesce();
    bus_wr(A_RLD, 32'h0100_0004);
    bus_wr(A_CTRL, 32'h7);
    first_k = 0; second_k = 0; hits = 0;
    for (int k = 1; k <= 12; k++) begin
      @(posedge clk); @(negedge clk);
      if (irq) begin
        hits++;
        if (hits == 1) first_k = k;
        if (hits == 2) second_k = k;
      end
    end
    check("R5", "first wrap after reload+1 ticks", first_k, 5);
    check("R5", "second wrap one period later", second_k, 10);
    check("R6", "one-cycle pulses in 12 cycles", hits, 2);
    bus_wr(A_CTRL, 32'h0);
    bus_rd(A_CUR, v);  check("R4", "current reads zero when off", v, 32'h0);
    bus_rd(A_CTRL, v); check("R3", "flag visible", v, FLAG);
    bus_rd(A_CTRL, v); check("R3", "flag cleared by read", v, 32'h0);
  endtask

  task automatic t_no_irq();
    logic [31:0] v;
    int hits;
    quiesce();
    bus_wr(A_RLD, 32'h2);
    bus_wr(A_CTRL, 32'h5);
    hits = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); @(negedge clk);
      if (irq) hits++;
    end
    check("R6", "no pulse with bit1 clear", hits, 0);
    bus_rd(A_CTRL, v); check("R6", "flag without interrupt", v, FLAG | 32'h5);
  endtask

  task automatic t_ref_source();
    logic [31:0] v;
    int early;
    quiesce();
    bus_wr(A_RLD, 32'h3);
    bus_wr(A_CTRL, 32'h3);
    idle(10);
    bus_rd(A_CUR, v); check("R5", "no tick without strobe", v, 32'h3);
    early = 0;
    for (int p = 1; p <= 4; p++) begin
      ref_tick = 1'b1;
      @(posedge clk); @(negedge clk);
      ref_tick = 1'b0;
      if (p < 4 && irq) early++;
      if (p == 4) check("R5", "wrap on 4th strobe", {31'b0, irq}, 32'h1);
      @(posedge clk); @(negedge clk);
      if (irq) early++;
      @(posedge clk); @(negedge clk);
      if (irq) early++;
    end
    check("R6", "pulses outside wrap", early, 0);
  endtask

  task automatic t_zero_reload();
    logic [31:0] v;
    int hits, first_k;
    quiesce();
    bus_wr(A_RLD, 32'h0);
    bus_wr(A_CTRL, 32'h7);
    hits = 0; first_k = 0;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk); @(negedge clk);
      if (irq) begin hits++; if (hits == 1) first_k = k; end
    end
    check("R7", "zero reload wraps once", hits, 1);
    check("R7", "wrap on first tick", first_k, 1);
    bus_rd(A_CTRL, v); check("R7", "run cleared by zero reload", v, FLAG | 32'h6);
  endtask

  task automatic t_count_write();
    logic [31:0] v;
    quiesce();
    bus_wr(A_RLD, 32'h3);
    bus_wr(A_CTRL, 32'h5);
    idle(10);
    bus_wr(A_RLD, 32'd100);
    bus_wr(A_CUR, 32'h55);
    bus_rd(A_CUR, v);  check("R8", "restart from reload", v, 32'd100);
    bus_rd(A_CTRL, v); check("R8", "write clears flag", v, 32'h5);
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_RLD, 32'd7);
    bus_wr(A_CUR, 32'h1);
    bus_wr(A_CTRL, 32'h4);
    idle(3);
    bus_wr(A_CTRL, 32'h5);
    bus_rd(A_CUR, v);  check("R4", "enable loads reload", v, 32'd7);
  endtask

  task automatic t_collisions();
    logic [31:0] v;
    // read on the wrap edge
    quiesce();
    bus_wr(A_RLD, 32'h4);
    bus_wr(A_CTRL, 32'h5);
    idle(4);
    bus_rd(A_CTRL, v); check("R3", "read on wrap edge sees old flag", v, 32'h5);
    bus_rd(A_CTRL, v); check("R3", "wrap wins over read clear", v, FLAG | 32'h5);
    // current write on the wrap edge
    quiesce();
    bus_wr(A_CTRL, 32'h7);
    idle(4);
    bus_wr(A_CUR, 32'h0);
    check("R8", "no pulse when write hits wrap", {31'b0, irq}, 32'h0);
    bus_rd(A_CUR, v);  check("R8", "count restarted", v, 32'h4);
    bus_rd(A_CTRL, v); check("R8", "wrap suppressed", v, 32'h7);
    // control write on the self-stop edge
    quiesce();
    bus_wr(A_RLD, 32'h0);
    bus_wr(A_CTRL, 32'h5);
    bus_wr(A_CTRL, 32'h5);
    bus_rd(A_CTRL, v); check("R7", "control write keeps run", v, FLAG | 32'h5);
    bus_rd(A_CTRL, v); check("R7", "next wrap stops", v, FLAG | 32'h4);
    bus_rd(A_CTRL, v); check("R3", "flag cleared after stop", v, 32'h4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ref_tick = 1'b0; sel = 1'b0; we = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_fields();
    t_period();
    t_no_irq();
    t_ref_source();
    t_zero_reload();
    t_count_write();
    t_collisions();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule